// File: doc/BRIEF.md
# PCI Slot Interrupt Router

This block collects the four interrupt request pins (INTA to INTD) of every PCI slot on a board and folds them into a single interrupt request toward the CPU interrupt controller. A fixed board table first assigns each slot pin to one internal interrupt line. Internal interrupt numbers start at 32, and a line index is the interrupt number minus 32.

Each internal line then contributes to the upstream output according to two configuration words held elsewhere. The bit of the edge-select word at the line's index selects edge mode or level mode. The bit of the polarity word at the same index decides, in level mode, whether an active line raises the output or keeps it low. An edge-mode line gives a single one-cycle pulse when it becomes active. The contributions of all lines are ORed and registered, so the output follows its inputs one clock later.

An asynchronous active-low reset is applied at once. Its release is synchronized inside the block and takes effect two clock edges after `rst_n` rises.

Top module: `pci_irq_router`

## Requirements
- R1: While reset is held, and until its synchronized release, `cpu_irq` is 0 whatever the requests and configuration words are.
- R2: Slot 5 routes pin n (request bit 5*4+n, n = 0..3) to internal line n.
- R3: Slot 6 routes all four pins to line 4. Slot 7 routes all four pins to line 5.
- R4: Slot s in 8..12 routes pin n to line (s - 8 + n) + 6, so lines 6 to 13 are reachable.
- R5: Any other slot forwards its pin number untranslated. That number is below the base of 32, so it reaches no internal line, and requests from these slots never move `cpu_irq`.
- R6: A line whose `edge_sel` bit is 0 is in level mode. If its `polarity` bit is 1, `cpu_irq` is 1 one cycle after the line becomes active and stays 1 while it is held. If its `polarity` bit is 0, the line keeps its contribution at 0.
- R7: A line whose `edge_sel` bit is 1 is in edge mode. A rising edge of the line gives exactly one cycle of `cpu_irq` = 1, one cycle later. Holding the line gives no further pulse, and a new pulse needs the line to fall and rise again.
- R8: A line is active when any request routed to it is active. `cpu_irq` is the OR of all line contributions. A second request on a line that is already active causes no new edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| slot_req | input | NUM_SLOTS*4 | Interrupt request pins, bit slot*4+pin, active high |
| edge_sel | input | NUM_LINES | Per-line mode: 1 = edge pulse, 0 = level |
| polarity | input | NUM_LINES | Per-line level-mode polarity: 1 = raise, 0 = keep low |
| cpu_irq | output | 1 | Registered interrupt request to the CPU controller |

## Verification
An edge pulse on one line and a held level on another line can fall in the same cycle. When they do, the pulse is hidden by the OR, and its end must not drop the level output. The bench sets line 4 (slot 6) to level mode with polarity set and line 5 (slot 7) to edge mode. It raises slot 6, then raises slot 7 while slot 6 is held, then releases slot 6 while slot 7 is still held. The output must stay 1 through the overlap and fall one cycle after the release, with no late pulse. The same edge is then repeated with line 4 quiet, so the bare pulse can be seen on its own.

// File: rtl/pci_irq_router_pkg.sv
package pci_irq_router_pkg;

  localparam int IRQ_BASE      = 32;
  localparam int PINS_PER_SLOT = 4;

  // Board routing table: interrupt number for (slot, pin).
  function automatic int route_irq(input int slot, input int pin);
    int num;
    if (slot == 5)                      num = (pin % 4) + IRQ_BASE;
    else if (slot == 6)                 num = 4 + IRQ_BASE;
    else if (slot == 7)                 num = 5 + IRQ_BASE;
    else if (slot >= 8 && slot <= 12)   num = (slot - 8 + pin) + 6 + IRQ_BASE;
    else                                num = pin; // untranslated
    return num;
  endfunction

endpackage

// File: rtl/irq_reset_sync.sv
module irq_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/irq_slot_map.sv
module irq_slot_map
  import pci_irq_router_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  parameter int NUM_LINES = 32
) (
  input  logic [NUM_SLOTS*PINS_PER_SLOT-1:0] slot_req,
  output logic [NUM_LINES-1:0]               line_act
);
  localparam int NREQ = NUM_SLOTS * PINS_PER_SLOT;

  // Constant mask of the request bits that feed one line.
  function automatic logic [NREQ-1:0] source_mask(input int line);
    logic [NREQ-1:0] m;
    m = '0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      for (int p = 0; p < PINS_PER_SLOT; p++) begin
        if (route_irq(s, p) - IRQ_BASE == line) m[s*PINS_PER_SLOT+p] = 1'b1;
      end
    end
    return m;
  endfunction

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    localparam logic [NREQ-1:0] SRC = source_mask(l);
    assign line_act[l] = |(slot_req & SRC);
  end
endmodule

// File: rtl/irq_line_trigger.sv
module irq_line_trigger #(
  parameter int NUM_LINES = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] line_act,
  input  logic [NUM_LINES-1:0] edge_sel,
  input  logic [NUM_LINES-1:0] polarity,
  output logic [NUM_LINES-1:0] contrib
);
  logic [NUM_LINES-1:0] act_q;
  logic [NUM_LINES-1:0] act_d;
  logic                 act_en;

  assign act_en = 1'b1;

  always_comb begin
    act_d = act_en ? line_act : act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= '0;
    else        act_q <= act_d;
  end

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_mode
    logic rise;
    assign rise = line_act[l] & ~act_q[l];
    always_comb begin
      if (edge_sel[l]) contrib[l] = rise;
      else             contrib[l] = line_act[l] & polarity[l];
    end
  end
endmodule

// File: rtl/pci_irq_router.sv
module pci_irq_router
  import pci_irq_router_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  parameter int NUM_LINES = 32
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [NUM_SLOTS*PINS_PER_SLOT-1:0] slot_req,
  input  logic [NUM_LINES-1:0]               edge_sel,
  input  logic [NUM_LINES-1:0]               polarity,
  output logic                               cpu_irq
);
  logic                 rst_q_n;
  logic [NUM_LINES-1:0] line_act;
  logic [NUM_LINES-1:0] contrib;
  logic                 irq_d;
  logic                 irq_q;

  irq_reset_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  irq_slot_map #(.NUM_SLOTS(NUM_SLOTS), .NUM_LINES(NUM_LINES)) u_map (
    .slot_req (slot_req),
    .line_act (line_act)
  );

  irq_line_trigger #(.NUM_LINES(NUM_LINES)) u_trig (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .line_act (line_act),
    .edge_sel (edge_sel),
    .polarity (polarity),
    .contrib  (contrib)
  );

  always_comb begin
    irq_d = |contrib;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) irq_q <= 1'b0;
    else          irq_q <= irq_d;
  end

  assign cpu_irq = irq_q;
endmodule

// File: rtl/pci_irq_router_chk.sv
module pci_irq_router_chk #(
  parameter int NUM_LINES = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 rst_q_n,
  input logic [NUM_LINES-1:0] line_act,
  input logic [NUM_LINES-1:0] edge_sel,
  input logic [NUM_LINES-1:0] polarity,
  input logic                 cpu_irq
);
  // R1: output held low while the synchronized reset is active
  p_reset_quiet_r1: assert property (@(posedge clk) !rst_q_n |-> !cpu_irq);

  // R8: a high output always traces back to an active line
  p_needs_source_r8: assert property (@(posedge clk) disable iff (!rst_q_n)
    cpu_irq |-> $past(|line_act));

  // R6: all-level, all-raise configuration follows the OR of the lines
  p_level_follow_r6: assert property (@(posedge clk) disable iff (!rst_q_n)
    (edge_sel == '0 && polarity == '1) |=> (cpu_irq == $past(|line_act)));

  // R6: all-level, all-clear polarity keeps the output low
  p_pol_clear_low_r6: assert property (@(posedge clk) disable iff (!rst_q_n)
    (edge_sel == '0 && polarity == '0) |=> !cpu_irq);

  // R7: with every line in edge mode, a pulse ends unless lines changed
  p_edge_single_r7: assert property (@(posedge clk) disable iff (!rst_q_n)
    (edge_sel == '1 && $stable(edge_sel) && cpu_irq && $stable(line_act)) |=> !cpu_irq);
endmodule

bind pci_irq_router pci_irq_router_chk #(.NUM_LINES(NUM_LINES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rst_q_n  (rst_q_n),
  .line_act (line_act),
  .edge_sel (edge_sel),
  .polarity (polarity),
  .cpu_irq  (cpu_irq)
);

// File: tb/pci_irq_router_tb_top.sv
module pci_irq_router_tb_top;
  localparam int NS = 16;
  localparam int NL = 32;

  logic          clk;
  logic          rst_n;
  logic [NS*4-1:0] slot_req;
  logic [NL-1:0] edge_sel;
  logic [NL-1:0] polarity;
  logic          cpu_irq;

  int checks;
  int errors;
  bit done;

  pci_irq_router #(.NUM_SLOTS(NS), .NUM_LINES(NL)) dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .slot_req (slot_req),
    .edge_sel (edge_sel),
    .polarity (polarity),
    .cpu_irq  (cpu_irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Expected line from the routing requirements, -1 when none.
  function automatic int exp_line(input int s, input int p);
    if (s == 5) return p;                      // R2
    if (s == 6) return 4;                      // R3
    if (s == 7) return 5;                      // R3
    if (s >= 8 && s <= 12) return s - 8 + p + 6; // R4
    return -1;                                 // R5
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: cpu_irq=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic clear_all();
    slot_req = '0;
    edge_sel = '0;
    polarity = '0;
    step();
    step();
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    slot_req = '1;
    edge_sel = '0;
    polarity = '1;
    step();
    step();
    check(cpu_irq, 1'b0, "R1 during reset");
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(cpu_irq, 1'b0, "R1 sync release window");
    slot_req = '0;
    step();
    step();
    step();
  endtask

  task automatic t_slot_map();
    for (int s = 0; s < NS; s++) begin
      for (int p = 0; p < 4; p++) begin
        int l;
        string tag;
        l = exp_line(s, p);
        if (s == 5) tag = "R2";
        else if (s == 6 || s == 7) tag = "R3";
        else if (s >= 8 && s <= 12) tag = "R4";
        else tag = "R5";
        edge_sel = '0;
        slot_req = '0;
        slot_req[s*4+p] = 1'b1;
        if (l >= 0) begin
          polarity = '0;
          polarity[l] = 1'b1;
          step();
          check(cpu_irq, 1'b1, $sformatf("%s slot %0d pin %0d own line", tag, s, p));
          polarity = ~polarity;
          step();
          check(cpu_irq, 1'b0, $sformatf("%s slot %0d pin %0d other lines", tag, s, p));
        end else begin
          polarity = '1;
          step();
          check(cpu_irq, 1'b0, $sformatf("%s slot %0d pin %0d unrouted", tag, s, p));
        end
        slot_req = '0;
        polarity = '0;
        step();
      end
    end
  endtask

  task automatic t_level();
    clear_all();
    polarity[2] = 1'b1;
    slot_req[5*4+2] = 1'b1;
    step();
    check(cpu_irq, 1'b1, "R6 level raise");
    step();
    step();
    check(cpu_irq, 1'b1, "R6 level held");
    slot_req[5*4+2] = 1'b0;
    step();
    check(cpu_irq, 1'b0, "R6 level release");
    polarity[2] = 1'b0;
    slot_req[5*4+2] = 1'b1;
    step();
    step();
    check(cpu_irq, 1'b0, "R6 polarity clear keeps low");
    slot_req = '0;
    step();
  endtask

  task automatic t_edge();
    clear_all();
    edge_sel = '1;
    slot_req[7*4+1] = 1'b1;
    step();
    check(cpu_irq, 1'b1, "R7 edge pulse");
    step();
    check(cpu_irq, 1'b0, "R7 pulse is one cycle");
    step();
    step();
    check(cpu_irq, 1'b0, "R7 held line no repeat");
    slot_req[7*4+1] = 1'b0;
    step();
    check(cpu_irq, 1'b0, "R7 falling gives nothing");
    slot_req[7*4+1] = 1'b1;
    step();
    check(cpu_irq, 1'b1, "R7 second rise pulses");
    slot_req = '0;
    step();
  endtask

  task automatic t_share();
    clear_all();
    edge_sel = '1;
    slot_req[6*4+0] = 1'b1;
    step();
    check(cpu_irq, 1'b1, "R8 first request on line 4");
    step();
    slot_req[6*4+3] = 1'b1;
    step();
    check(cpu_irq, 1'b0, "R8 second request on active line");
    slot_req = '0;
    edge_sel = '0;
    polarity = '1;
    slot_req[8*4+0] = 1'b1;
    slot_req[5*4+0] = 1'b1;
    step();
    check(cpu_irq, 1'b1, "R8 two lines ORed");
    slot_req[8*4+0] = 1'b0;
    step();
    check(cpu_irq, 1'b1, "R8 one line left");
    slot_req[5*4+0] = 1'b0;
    step();
    check(cpu_irq, 1'b0, "R8 none left");
  endtask

  task automatic t_coincide();
    clear_all();
    edge_sel[5] = 1'b1;
    polarity[4] = 1'b1;
    slot_req[6*4+0] = 1'b1;
    step();
    check(cpu_irq, 1'b1, "R8 level line up");
    slot_req[7*4+0] = 1'b1;
    step();
    check(cpu_irq, 1'b1, "R8 pulse under level");
    step();
    check(cpu_irq, 1'b1, "R6 level survives pulse end");
    slot_req[6*4+0] = 1'b0;
    step();
    check(cpu_irq, 1'b0, "R7 no late pulse after level drop");
    slot_req[7*4+0] = 1'b0;
    step();
    slot_req[7*4+0] = 1'b1;
    step();
    check(cpu_irq, 1'b1, "R7 bare pulse");
    step();
    check(cpu_irq, 1'b0, "R7 bare pulse ends");
    slot_req = '0;
    step();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    checks = 0;
    errors = 0;
    done = 1'b0;
    rst_n = 1'b0;
    slot_req = '0;
    edge_sel = '0;
    polarity = '0;
    @(negedge clk);
    t_reset();
    t_slot_map();
    t_level();
    t_edge();
    t_share();
    t_coincide();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule